// File: doc/BRIEF.md
# Serial Port Interrupt Identification

This block sits beside the receive and transmit paths of a serial port and tells the host CPU which interrupt it should service first. Five pending conditions come in as level inputs: receiver line status, received data available, character timeout, transmitter holding register empty and modem status. A per-source enable mask filters them. The highest-priority enabled source is encoded into an 8-bit read-only identification value, which also carries FIFO-mode status bits. An interrupt request line is raised whenever any enabled source is pending.

The identification value is registered. It holds steady for as long as the CPU read strobe is high. New sources that arrive during a read therefore cannot change the value the CPU is reading. The pending state present at the end of the access appears on the first clock edge after the strobe drops. Detecting each condition and clearing each source are done elsewhere.

Top module: `uart_int_ident`

## Requirements
- R1: After reset, idValue reads 0x01 and irqOut is 0.
- R2: Priority runs line status, then received data, then transmitter empty, then modem status. The code in bits 3..1 is 011, 010, 001 and 000 respectively.
- R3: In FIFO mode a pending character timeout reports code 110 in bits 3..1. It shares the received-data level, and when both are pending, received data (010) is reported.
- R4: In non-FIFO mode the timeout input is ignored and bit 3 reads 0.
- R5: Bits 5 and 4 always read 0.
- R6: Bits 7 and 6 both read 1 when fifoEnable is 1, and both read 0 otherwise.
- R7: Bit 0 reads 0 when any enabled source is pending. When none is pending, the value reads 0x01 in non-FIFO mode and 0xC1 in FIFO mode.
- R8: srcEnable bit 0 enables received data and timeout, bit 1 enables transmitter empty, bit 2 enables line status and bit 3 enables modem status. A disabled source is neither reported nor counted as pending.
- R9: While idRead is high at a clock edge, idValue does not change. It takes up the current state at the first edge where idRead is low.
- R10: irqOut is high when any enabled source was pending at the previous edge. It is not frozen by idRead, and outside a read it equals the inverse of bit 0.
- R11: idValue reflects the inputs sampled at the preceding clock edge, so the latency is one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineStatPend | input | 1 | Receiver line status condition pending |
| rxDataPend | input | 1 | Received data available pending |
| rxTimeoutPend | input | 1 | Character timeout pending |
| txEmptyPend | input | 1 | Transmitter holding register empty pending |
| modemPend | input | 1 | Modem status change pending |
| fifoEnable | input | 1 | FIFO mode enable |
| srcEnable | input | 4 | Per-source enable mask (see R8) |
| idRead | input | 1 | CPU read access of the identification value in progress |
| idValue | output | 8 | Identification value |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench sweeps every combination of the five pending inputs, the four mask bits and the FIFO mode: 1024 patterns in all. For each pattern it compares the value and the request line against an arithmetic model. This sweep separates the priority order and the masking of each source. It also shows the timeout taking effect only in FIFO mode and losing to received data. A separate sequence changes the sources while a read is held and shows that the value freezes while the request line keeps moving. It also confirms that the new state appears one edge after the read ends.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;
  localparam int ID_W   = 8;
  localparam int MASK_W = 4;

  // Mask bit positions (part of the block's behaviour)
  localparam int EN_RX   = 0;
  localparam int EN_TX   = 1;
  localparam int EN_LINE = 2;
  localparam int EN_MDM  = 3;

  typedef enum logic [2:0] {
    CODE_MODEM = 3'b000,
    CODE_TXE   = 3'b001,
    CODE_RXD   = 3'b010,
    CODE_LINE  = 3'b011,
    CODE_TMO   = 3'b110
  } iidCode_t;

  typedef struct packed {
    logic capture;   // load the identification register
    logic irqLoad;   // load the request flop
  } iidStrobe_t;
endpackage

// File: rtl/uart_iid_ctrl.sv
module uart_iid_ctrl
  import uart_iid_pkg::*;
(
  input  logic       idRead,
  output iidStrobe_t strobe
);
  always_comb begin
    strobe.capture = !idRead;
    strobe.irqLoad = 1'b1;
  end
endmodule

// File: rtl/uart_iid_datapath.sv
module uart_iid_datapath
  import uart_iid_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineStatPend,
  input  logic              rxDataPend,
  input  logic              rxTimeoutPend,
  input  logic              txEmptyPend,
  input  logic              modemPend,
  input  logic              fifoEnable,
  input  logic [MASK_W-1:0] srcEnable,
  input  iidStrobe_t        strobe,
  output logic [ID_W-1:0]   idValue,
  output logic              irqOut
);
  localparam logic [ID_W-1:0] IDLE_VALUE = ID_W'(1);

  logic       lineEn, rxEn, tmoEn, txEn, mdmEn;
  logic       anyPend;
  iidCode_t   code;
  logic [ID_W-1:0] nextValue;
  logic [ID_W-1:0] idReg;
  logic       irqReg;

  always_comb begin
    lineEn = lineStatPend  & srcEnable[EN_LINE];
    rxEn   = rxDataPend    & srcEnable[EN_RX];
    tmoEn  = rxTimeoutPend & srcEnable[EN_RX] & fifoEnable;
    txEn   = txEmptyPend   & srcEnable[EN_TX];
    mdmEn  = modemPend     & srcEnable[EN_MDM];
    anyPend = lineEn | rxEn | tmoEn | txEn | mdmEn;
  end

  always_comb begin
    if (lineEn)     code = CODE_LINE;
    else if (rxEn)  code = CODE_RXD;
    else if (tmoEn) code = CODE_TMO;
    else if (txEn)  code = CODE_TXE;
    else            code = CODE_MODEM;
  end

  always_comb begin
    nextValue       = '0;
    nextValue[0]    = !anyPend;
    nextValue[3:1]  = code;
    nextValue[7:6]  = {2{fifoEnable}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idReg <= IDLE_VALUE;
    end else if (strobe.capture) begin
      idReg <= nextValue;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqReg <= 1'b0;
    end else if (strobe.irqLoad) begin
      irqReg <= anyPend;
    end
  end

  assign idValue = idReg;
  assign irqOut  = irqReg;
endmodule

// File: rtl/uart_int_ident.sv
module uart_int_ident
  import uart_iid_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineStatPend,
  input  logic              rxDataPend,
  input  logic              rxTimeoutPend,
  input  logic              txEmptyPend,
  input  logic              modemPend,
  input  logic              fifoEnable,
  input  logic [MASK_W-1:0] srcEnable,
  input  logic              idRead,
  output logic [ID_W-1:0]   idValue,
  output logic              irqOut
);
  iidStrobe_t strobe;

  uart_iid_ctrl u_ctrl (
    .idRead (idRead),
    .strobe (strobe)
  );

  uart_iid_datapath u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .lineStatPend  (lineStatPend),
    .rxDataPend    (rxDataPend),
    .rxTimeoutPend (rxTimeoutPend),
    .txEmptyPend   (txEmptyPend),
    .modemPend     (modemPend),
    .fifoEnable    (fifoEnable),
    .srcEnable     (srcEnable),
    .strobe        (strobe),
    .idValue       (idValue),
    .irqOut        (irqOut)
  );
endmodule

// File: rtl/uart_int_ident_chk.sv
module uart_int_ident_chk (
  input logic       clk,
  input logic       rstN,
  input logic       idRead,
  input logic [7:0] idValue,
  input logic       irqOut
);
  assert_resv_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    idValue[5:4] == 2'b00);

  assert_mode_bits_pair_R6: assert property (@(posedge clk) disable iff (!rstN)
    idValue[7] == idValue[6]);

  assert_tmo_fifo_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    idValue[3] |-> (idValue[2] && idValue[7]));

  assert_read_freeze_R9: assert property (@(posedge clk) disable iff (!rstN)
    idRead |=> $stable(idValue));

  assert_irq_matches_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(idRead) |-> (irqOut == !idValue[0]));

  assert_idle_code_R7: assert property (@(posedge clk) disable iff (!rstN)
    idValue[0] |-> (idValue[3:1] == 3'b000));
endmodule

bind uart_int_ident uart_int_ident_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .idRead  (idRead),
  .idValue (idValue),
  .irqOut  (irqOut)
);

// File: tb/sim_uart_int_ident.sv
module sim_uart_int_ident;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineStatPend = 0, rxDataPend = 0, rxTimeoutPend = 0;
  logic       txEmptyPend = 0, modemPend = 0, fifoEnable = 0, idRead = 0;
  logic [3:0] srcEnable = 0;
  logic [7:0] idValue;
  logic       irqOut;
  int         nChecks = 0;
  int         nFails = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  uart_int_ident u0 (
    .clk(clk), .rstN(rstN), .lineStatPend(lineStatPend), .rxDataPend(rxDataPend),
    .rxTimeoutPend(rxTimeoutPend), .txEmptyPend(txEmptyPend), .modemPend(modemPend),
    .fifoEnable(fifoEnable), .srcEnable(srcEnable), .idRead(idRead),
    .idValue(idValue), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // s = {modem, txEmpty, timeout, rxData, line}
  function automatic logic [7:0] model(input logic [4:0] s, input logic [3:0] m, input logic f);
    logic ln, rx, to, tx, md;
    logic [2:0] c;
    ln = s[0] & m[2];
    rx = s[1] & m[0];
    to = s[2] & m[0] & f;
    tx = s[3] & m[1];
    md = s[4] & m[3];
    c = ln ? 3'd3 : rx ? 3'd2 : to ? 3'd6 : tx ? 3'd1 : 3'd0;
    return {f, f, 2'b00, c, ~(ln | rx | to | tx | md)};
  endfunction

  task automatic drive(input logic [4:0] s, input logic [3:0] m, input logic f);
    lineStatPend = s[0]; rxDataPend = s[1]; rxTimeoutPend = s[2];
    txEmptyPend = s[3]; modemPend = s[4]; srcEnable = m; fifoEnable = f;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] e, a, b;
    repeat (2) @(negedge clk);
    check("R1 reset value", idValue, 8'h01);
    check("R1 reset irq", {7'b0, irqOut}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", idValue, 8'h01);

    // Exhaustive sweep: R2 R3 R4 R5 R6 R7 R8 R10 R11
    for (int i = 0; i < 1024; i++) begin
      drive(i[4:0], i[8:5], i[9]);
      @(negedge clk);
      e = model(i[4:0], i[8:5], i[9]);
      check("R2/R3/R4/R5/R6/R7/R8/R11 value", idValue, e);
      check("R10 irq", {7'b0, irqOut}, {7'b0, ~e[0]});
    end

    // Named corner cases
    drive(5'b00110, 4'hF, 1'b1); @(negedge clk);
    check("R3 rx beats timeout", idValue, 8'hC4);
    drive(5'b00100, 4'hF, 1'b1); @(negedge clk);
    check("R3 timeout alone", idValue, 8'hCC);
    drive(5'b00100, 4'hF, 1'b0); @(negedge clk);
    check("R4 timeout ignored non-FIFO", idValue, 8'h01);
    drive(5'b00000, 4'hF, 1'b1); @(negedge clk);
    check("R7 idle FIFO", idValue, 8'hC1);
    drive(5'b00001, 4'b1011, 1'b0); @(negedge clk);
    check("R8 line masked", idValue, 8'h01);

    // Freeze during read: R9 R10
    drive(5'b01000, 4'hF, 1'b0); @(negedge clk);
    a = model(5'b01000, 4'hF, 1'b0);
    check("R9 before read", idValue, a);
    idRead = 1'b1;
    drive(5'b00001, 4'hF, 1'b1);
    b = model(5'b00001, 4'hF, 1'b1);
    @(negedge clk);
    check("R9 frozen 1", idValue, a);
    drive(5'b00000, 4'hF, 1'b0);
    @(negedge clk);
    check("R9 frozen 2", idValue, a);
    check("R10 irq not frozen", {7'b0, irqOut}, 8'h00);
    drive(5'b00001, 4'hF, 1'b1);
    @(negedge clk);
    check("R9 frozen 3", idValue, a);
    check("R10 irq follows", {7'b0, irqOut}, 8'h01);
    idRead = 1'b0;
    @(negedge clk);
    check("R9 update after read", idValue, b);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule